// File: doc/BRIEF.md
# Packed Media Integer ALU

This block performs the small integer primitives that audio and video kernels need, on a 64-bit operand pair. The pair is split into independent lanes of 8, 16 or 32 bits, and no carry or borrow ever crosses a lane edge. The operations are rounding average, absolute difference, absolute difference added into a per-lane accumulator, and minimum and maximum. Each operation can treat its lanes as signed or unsigned.

A caller presents both source words, the accumulator word, an opcode, a lane-width code and two flags (signedness and record) together with a one-cycle valid strobe. One clock later the block shows the packed result and a 3-bit condition field, and it raises its output valid for that cycle. When record is set on minimum or maximum, the condition field describes how lane 0 of the two inputs compare to each other. It does not describe the value that was returned. Between strobes the result and condition field keep their last values.

Top module: `media_lane_alu`

## Requirements
- R1: While reset is asserted and after its release, outValid, result and condOut are all zero until the first strobe.
- R2: result and condOut update one clock after a cycle with inValid high, and outValid is high exactly in the cycle after each such strobe. Without a strobe, result and condOut hold their values.
- R3: Opcode 0 (average) gives (a + b + 1) >> 1 in each lane, with the shift arithmetic when isSigned is 1. The sum is formed without overflow, so for example 255 and 255 unsigned give 255, and -128 and -128 signed give -128.
- R4: Opcode 1 (absolute difference) gives a − b when a > b and b − a otherwise, per lane, truncated to the lane width. The comparison is signed when isSigned is 1.
- R5: Opcode 2 (difference accumulate) gives the matching lane of accIn plus the lane's absolute difference from R4, wrapping modulo 2^width.
- R6: Opcode 3 (minimum) returns a when a < b and b otherwise. Opcode 4 (maximum) returns a when a > b and b otherwise. The compare is signed when isSigned is 1.
- R7: laneSel 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes. Lane k occupies bits k*width upward, and lanes are fully independent.
- R8: When recEn is 1 and the opcode is 3 or 4, condOut is {a<b, a>b, a==b} for lane 0, using the same signedness as the operation, whichever operand was returned.
- R9: condOut is zero after any strobe where recEn is 0 or the opcode is not 3 or 4.
- R10: Opcodes 5, 6 and 7 produce a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| srcA | input | 64 | First operand word |
| srcB | input | 64 | Second operand word |
| accIn | input | 64 | Per-lane accumulator word |
| opSel | input | 3 | Operation code |
| laneSel | input | 2 | Lane width code |
| isSigned | input | 1 | Signed lane interpretation |
| recEn | input | 1 | Record condition for min/max |
| outValid | output | 1 | Result valid, one cycle after strobe |
| result | output | 64 | Packed lane results |
| condOut | output | 3 | {less, greater, equal} of lane 0 |

## Verification
The bench builds the block with its default 64-bit word. In 8-bit mode that word carries eight lanes per strobe, so every pair of 8-bit values can be swept for each opcode and signedness in a few tens of thousands of cycles. All sign and overflow corners of average and difference are covered this way. The 16-bit and 32-bit modes, the reserved opcodes, accumulator wrap and the hold behaviour without a strobe are exercised with pseudo-random words and chosen edge values.

// File: rtl/media_alu_pkg.sv
package media_alu_pkg;

  typedef enum logic [2:0] {
    OP_AVG    = 3'd0,
    OP_ABSD   = 3'd1,
    OP_ABSACC = 3'd2,
    OP_MIN    = 3'd3,
    OP_MAX    = 3'd4
  } op_e;

  typedef struct packed {
    logic load;
    logic rec;
  } ctrl_t;

endpackage

// File: rtl/media_lane_unit.sv
module media_lane_unit
  import media_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] acc,
  input  logic [2:0]   op,
  input  logic         sgn,
  output logic [W-1:0] res,
  output logic [2:0]   flags
);
  localparam int EW = W + 2;

  logic signed [EW-1:0] ax, bx, sumAvg, diff, absVal;
  logic lt, gt, eq;
  logic [W-1:0] absW;

  always_comb begin
    ax     = {{2{sgn & a[W-1]}}, a};
    bx     = {{2{sgn & b[W-1]}}, b};
    sumAvg = ax + bx + EW'(1);
    diff   = ax - bx;
    lt     = diff[EW-1];
    eq     = (diff == '0);
    gt     = !lt && !eq;
    absVal = lt ? -diff : diff;
    absW   = absVal[W-1:0];
  end

  always_comb begin
    case (op)
      OP_AVG:    res = sumAvg[W:1];
      OP_ABSD:   res = absW;
      OP_ABSACC: res = acc + absW;
      OP_MIN:    res = lt ? a : b;
      OP_MAX:    res = gt ? a : b;
      default:   res = '0;
    endcase
    flags = {lt, gt, eq};
  end

  logic unusedBits;
  assign unusedBits = ^{sumAvg[EW-1], sumAvg[0], absVal[EW-1:W]};

endmodule

// File: rtl/media_alu_ctrl.sv
module media_alu_ctrl
  import media_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] opSel,
  input  logic       recEn,
  output ctrl_t      ctrl,
  output logic       outValid
);
  logic isMinMax;

  always_comb begin
    isMinMax  = (opSel == OP_MIN) || (opSel == OP_MAX);
    ctrl.load = inValid;
    ctrl.rec  = inValid && recEn && isMinMax;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/media_alu_dp.sv
module media_alu_dp
  import media_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] accIn,
  input  logic [2:0]        opSel,
  input  logic [1:0]        laneSel,
  input  logic              isSigned,
  output logic [DATA_W-1:0] resultQ,
  output logic [2:0]        condQ
);
  localparam int NUM_W = 3;

  logic [NUM_W-1:0][DATA_W-1:0] resW;
  logic [NUM_W-1:0][2:0]        flagW;

  for (genvar gw = 0; gw < NUM_W; gw++) begin : g_width
    localparam int LW = 8 << gw;
    localparam int NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [LW-1:0] laneRes;
      logic [2:0]    laneFlags;
      media_lane_unit #(.W(LW)) u_lane (
        .a    (srcA[l*LW +: LW]),
        .b    (srcB[l*LW +: LW]),
        .acc  (accIn[l*LW +: LW]),
        .op   (opSel),
        .sgn  (isSigned),
        .res  (laneRes),
        .flags(laneFlags)
      );
      assign resW[gw][l*LW +: LW] = laneRes;
      if (l == 0) begin : g_first
        assign flagW[gw] = laneFlags;
      end else begin : g_rest
        logic [2:0] unusedFlags;
        assign unusedFlags = laneFlags;
      end
    end
  end

  logic [1:0] widthIdx;
  always_comb widthIdx = (laneSel == 2'd3) ? 2'd2 : laneSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      condQ   <= '0;
    end else if (ctrl.load) begin
      resultQ <= resW[widthIdx];
      condQ   <= ctrl.rec ? flagW[widthIdx] : 3'b000;
    end
  end

  p_hold_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(resultQ) && $stable(condQ)));
  p_cond_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.rec) |=> (condQ == 3'b000));
  p_cond_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rec |=> ($countones(condQ) == 1));
  p_cond_zero_or_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(condQ));

endmodule

// File: rtl/media_lane_alu.sv
module media_lane_alu
  import media_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] accIn,
  input  logic [2:0]        opSel,
  input  logic [1:0]        laneSel,
  input  logic              isSigned,
  input  logic              recEn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [2:0]        condOut
);
  ctrl_t ctrl;

  media_alu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opSel   (opSel),
    .recEn   (recEn),
    .ctrl    (ctrl),
    .outValid(outValid)
  );

  media_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .srcA    (srcA),
    .srcB    (srcB),
    .accIn   (accIn),
    .opSel   (opSel),
    .laneSel (laneSel),
    .isSigned(isSigned),
    .resultQ (result),
    .condQ   (condOut)
  );

endmodule

// File: tb/tb_media_lane_alu.sv
module tb_media_lane_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcA = '0, srcB = '0, accIn = '0;
  logic [2:0]  opSel = '0;
  logic [1:0]  laneSel = '0;
  logic        isSigned = 1'b0, recEn = 1'b0;
  logic        outValid;
  logic [63:0] result;
  logic [2:0]  condOut;

  int checks = 0;
  int errors = 0;
  logic [63:0] lfsr = 64'h9E3779B97F4A7C15;

  always #4 clk = ~clk;

  media_lane_alu dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .accIn(accIn), .opSel(opSel), .laneSel(laneSel), .isSigned(isSigned),
    .recEn(recEn), .outValid(outValid), .result(result), .condOut(condOut)
  );

  function automatic int widthOf(input logic [1:0] ls);
    return (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
  endfunction

  function automatic longint laneVal(input logic [63:0] w, input int k, input int lw, input logic s);
    longint u;
    u = longint'((w >> (k*lw)) & ((64'd1 << lw) - 1));
    if (s && u >= (longint'(1) << (lw-1))) u = u - (longint'(1) << lw);
    return u;
  endfunction

  function automatic logic [63:0] refResult(input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] acc, input logic [2:0] op, input logic [1:0] ls, input logic s);
    logic [63:0] r;
    int lw;
    longint ai, bi, ci, v, m;
    lw = widthOf(ls);
    m = (longint'(1) << lw) - 1;
    r = '0;
    for (int k = 0; k < 64/lw; k++) begin
      ai = laneVal(a, k, lw, s);
      bi = laneVal(b, k, lw, s);
      ci = laneVal(acc, k, lw, 1'b0);
      case (op)
        3'd0: v = (ai + bi + 1) >>> 1;
        3'd1: v = (ai > bi) ? ai - bi : bi - ai;
        3'd2: v = ci + ((ai > bi) ? ai - bi : bi - ai);
        3'd3: v = (ai < bi) ? ai : bi;
        3'd4: v = (ai > bi) ? ai : bi;
        default: v = 0;
      endcase
      r = r | (64'(v & m) << (k*lw));
    end
    return r;
  endfunction

  function automatic logic [2:0] refCond(input logic [63:0] a, input logic [63:0] b,
      input logic [2:0] op, input logic [1:0] ls, input logic s, input logic rec);
    longint ai, bi;
    int lw;
    if (!rec || !(op == 3'd3 || op == 3'd4)) return 3'b000;
    lw = widthOf(ls);
    ai = laneVal(a, 0, lw, s);
    bi = laneVal(b, 0, lw, s);
    return {ai < bi, ai > bi, ai == bi};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  // drive at negedge, check at the next negedge (one register stage)
  task automatic doOp(input logic [63:0] a, input logic [63:0] b, input logic [63:0] acc,
      input logic [2:0] op, input logic [1:0] ls, input logic s, input logic rec, input string tag);
    logic [63:0] er;
    logic [2:0]  ec;
    srcA = a; srcB = b; accIn = acc; opSel = op; laneSel = ls;
    isSigned = s; recEn = rec; inValid = 1'b1;
    er = refResult(a, b, acc, op, ls, s);
    ec = refCond(a, b, op, ls, s, rec);
    @(negedge clk);
    check({reqOf(op), " ", tag}, result, er);
    check({"R8/R9 ", tag}, 64'(condOut), 64'(ec));
    check("R2 outValid", 64'(outValid), 64'd1);
  endtask

  function automatic logic [63:0] nextRand(input logic [63:0] x);
    return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic [63:0] a, b, c;
    logic [2:0] heldC;
    repeat (3) @(negedge clk);
    check("R1 outValid", 64'(outValid), 64'd0);
    check("R1 result", result, 64'd0);
    check("R1 condOut", 64'(condOut), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 result after release", result, 64'd0);
    check("R1 outValid after release", 64'(outValid), 64'd0);

    // exhaustive 8-bit lane sweep (R3..R7): eight b values per strobe
    for (int op = 0; op < 5; op++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 256; i++)
          for (int j = 0; j < 32; j++) begin
            a = {8{8'(i)}};
            b = '0;
            for (int k = 0; k < 8; k++) b[k*8 +: 8] = 8'(j*8 + k);
            c = {8{8'(i*7 + j)}};
            doOp(a, b, c, 3'(op), 2'd0, 1'(s), 1'(j & 1), "sweep8");
          end

    // 16/32-bit lanes and reserved opcodes, random words (R7, R10)
    for (int n = 0; n < 600; n++) begin
      lfsr = nextRand(lfsr); a = lfsr;
      lfsr = nextRand(lfsr); b = (n % 5 == 0) ? a : lfsr;
      lfsr = nextRand(lfsr); c = lfsr;
      doOp(a, b, c, 3'(n % 8), 2'(1 + n % 3), 1'(n / 3 % 2), 1'(n / 7 % 2), "R7 wide");
    end

    // edge values
    doOp({4{16'hFFFF}}, {4{16'hFFFF}}, '0, 3'd0, 2'd1, 1'b0, 1'b0, "R3 max unsigned avg");
    doOp({2{32'h80000000}}, {2{32'h80000000}}, '0, 3'd0, 2'd2, 1'b1, 1'b0, "R3 min signed avg");
    doOp({2{32'h7FFFFFFF}}, {2{32'h80000000}}, '0, 3'd1, 2'd3, 1'b1, 1'b0, "R4 signed span");
    doOp({2{32'h00000000}}, {2{32'hFFFFFFFF}}, {2{32'hFFFFFFFF}}, 3'd2, 2'd2, 1'b0, 1'b0, "R5 wrap");
    doOp(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, '0, 3'd0, 2'd0, 1'b0, 1'b0, "R7 no cross carry");
    doOp(64'h5, 64'h5, '0, 3'd3, 2'd0, 1'b1, 1'b1, "R8 equal");
    doOp(64'h80, 64'h01, '0, 3'd4, 2'd0, 1'b1, 1'b1, "R8 signed lt");
    doOp(64'h80, 64'h01, '0, 3'd4, 2'd0, 1'b0, 1'b1, "R8 unsigned gt");
    doOp(64'h80, 64'h01, '0, 3'd4, 2'd0, 1'b0, 1'b0, "R9 no record");
    doOp(64'h80, 64'h01, '0, 3'd1, 2'd0, 1'b0, 1'b1, "R9 not minmax");
    doOp(64'h1234, 64'h99, '0, 3'd7, 2'd1, 1'b0, 1'b1, "R10 reserved");

    // hold without strobe (R2)
    doOp(64'h10, 64'h02, '0, 3'd3, 2'd0, 1'b0, 1'b1, "R2 setup");
    held = result; heldC = condOut;
    inValid = 1'b0;
    srcA = '1; srcB = '0; opSel = 3'd0; recEn = 1'b0;
    @(negedge clk);
    check("R2 outValid low", 64'(outValid), 64'd0);
    check("R2 result hold", result, held);
    check("R2 cond hold", 64'(condOut), 64'(heldC));
    @(negedge clk);
    check("R2 result hold 2", result, held);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule